// File: doc/BRIEF.md
# Countdown Timer with Shared Interrupt Status

This block is a programmable down-counter that sits behind a small register port. A single 32-bit control word holds everything for the timer. The low 20 bits are the count, and three single-bit controls sit above it: run, interrupt enable and acknowledge. Software loads a count and sets run. From then on every cycle with the `tick` input high takes one off the count, and the count stops at zero.

When the count steps from one to zero with the interrupt enable set, a pending flag is latched. The flag stays set until software writes the control word with the acknowledge bit set. A separate read-only status word gathers the timer's pending flag and five request lines from neighbouring blocks at fixed bit positions. The `irq` output is high whenever any bit of that word is set.

Access is single-cycle. A write takes effect at the clock edge where `wr_en` is high. Reads are combinational from `addr`. Neither path has a handshake or back-pressure: the block accepts every write at once and always presents read data.

Top module: `tick_timer_irq`

## Requirements
- R1: A write to the control word (address 0x60) loads the count from bits 19:0, run from bit 24 and interrupt enable from bit 25. Reading the control word returns the count in bits 19:0, run in bit 24 and interrupt enable in bit 25. All other bits read 0, including bit 26.
- R2: In a cycle with `tick` high, run set, a nonzero count and no control-word write, the count drops by exactly one. If any of the first three conditions is missing, the count is unchanged.
- R3: A count of zero stays at zero on further ticks and never wraps.
- R4: The pending flag is set only by a tick that takes the count from 1 to 0 while interrupt enable is 1. Loading zero directly sets nothing. Reaching zero with interrupt enable at 0 sets nothing.
- R5: A control-word write with bit 26 set clears the pending flag. The same write still loads the count, run and enable fields.
- R6: When a control-word write and a tick fall in the same cycle, the written count is kept and no decrement or interrupt results from that tick.
- R7: The status word (address 0x64) is read-only. Bits 4:0 follow `src_req[4:0]` and bit 5 is the timer pending flag. Bits 31:6 read 0. Writes to it change nothing.
- R8: `irq` is high exactly when any status-word bit is 1.
- R9: After reset the count, run, interrupt enable and pending flag are all 0.
- R10: Reads from any other address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address for read and write |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| tick | input | 1 | Count-enable pulse |
| src_req | input | 5 | Level requests from other interrupt sources |
| irq | output | 1 | OR of the status word |

## Verification
The countdown is driven three ways: with back-to-back ticks, with ticks spaced by idle cycles, and with run cleared. Together these separate a counter that decrements on every clock from one that honours `tick` and run. The 1-to-0 step is exercised with the enable set, with the enable cleared, and after a direct load of zero, so only a real transition raises the flag. A write and a tick are placed in the same cycle to check write priority. An acknowledge is combined with a new count to confirm both effects occur. Several request-line patterns, plus a write aimed at the status word, show each bit's fixed position and that the status word cannot be written.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef struct packed {
    logic run;
    logic ien;
  } tmr_ctl_t;
endpackage

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int unsigned CNT_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CNT_W-1:0]    load_val,
  input  tt_pkg::tmr_ctl_t    load_ctl,
  input  logic                tick,
  output logic [CNT_W-1:0]    cnt,
  output tt_pkg::tmr_ctl_t    ctl,
  output logic                zero_hit
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic step;
  assign step     = tick && ctl.run && (cnt != '0) && !load;
  assign zero_hit = step && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ctl <= '0;
    end else if (load) begin
      cnt <= load_val;
      ctl <= load_ctl;
    end else if (step) begin
      cnt <= cnt - ONE;
    end
  end
endmodule

// File: rtl/tt_pending.sv
module tt_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= 1'b0;
    else if (clr) pend <= 1'b0;
    else if (set) pend <= 1'b1;
  end
endmodule

// File: rtl/tt_status.sv
module tt_status #(
  parameter int unsigned STAT_W    = 8,
  parameter int unsigned EXT_SRC   = 5,
  parameter int unsigned TIMER_SRC = 5
) (
  input  logic [EXT_SRC-1:0] src_req,
  input  logic               tmr_pend,
  output logic [STAT_W-1:0]  status,
  output logic               any
);
  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (i == TIMER_SRC) begin : g_tmr
      assign status[i] = tmr_pend;
    end else if (i < EXT_SRC) begin : g_ext
      assign status[i] = src_req[i];
    end else begin : g_rsv
      assign status[i] = 1'b0;
    end
  end
  assign any = |status;
endmodule

// File: rtl/tick_timer_irq.sv
module tick_timer_irq #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned RUN_BIT   = 24,
  parameter int unsigned IEN_BIT   = 25,
  parameter int unsigned ACK_BIT   = 26,
  parameter int unsigned EXT_SRC   = 5,
  parameter int unsigned TIMER_SRC = 5,
  parameter int unsigned STAT_W    = 8,
  parameter int unsigned TIMER_OFS = 32'h60,
  parameter int unsigned STAT_OFS  = 32'h64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick,
  input  logic [EXT_SRC-1:0] src_req,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] TMR_A  = ADDR_W'(TIMER_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

  logic               tmr_wr;
  logic [CNT_W-1:0]   cnt_q;
  tt_pkg::tmr_ctl_t   ctl_q;
  tt_pkg::tmr_ctl_t   new_ctl;
  logic               zero_hit;
  logic               pend_q;
  logic [STAT_W-1:0]  status;
  logic               unused_wr_bits;

  assign tmr_wr      = wr_en && (addr == TMR_A);
  assign new_ctl.run = wr_data[RUN_BIT];
  assign new_ctl.ien = wr_data[IEN_BIT];
  assign unused_wr_bits = ^wr_data;

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_wr),
    .load_val (wr_data[CNT_W-1:0]),
    .load_ctl (new_ctl),
    .tick     (tick),
    .cnt      (cnt_q),
    .ctl      (ctl_q),
    .zero_hit (zero_hit)
  );

  tt_pending u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (zero_hit && ctl_q.ien),
    .clr   (tmr_wr && wr_data[ACK_BIT]),
    .pend  (pend_q)
  );

  tt_status #(.STAT_W(STAT_W), .EXT_SRC(EXT_SRC), .TIMER_SRC(TIMER_SRC)) u_stat (
    .src_req  (src_req),
    .tmr_pend (pend_q),
    .status   (status),
    .any      (irq)
  );

  always_comb begin
    rd_data = '0;
    if (addr == TMR_A) begin
      rd_data[CNT_W-1:0] = cnt_q;
      rd_data[RUN_BIT]   = ctl_q.run;
      rd_data[IEN_BIT]   = ctl_q.ien;
    end else if (addr == STAT_A) begin
      rd_data[STAT_W-1:0] = status;
    end
  end
endmodule

// File: rtl/tt_timer_chk.sv
module tt_timer_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned ACK_BIT   = 26,
  parameter int unsigned EXT_SRC   = 5,
  parameter int unsigned TIMER_OFS = 32'h60,
  parameter int unsigned STAT_OFS  = 32'h64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              tick,
  input logic [EXT_SRC-1:0] src_req,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              run_q,
  input logic              ien_q,
  input logic              pend_q
);
  logic wr_t;
  assign wr_t = wr_en && (addr == ADDR_W'(TIMER_OFS));

  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_q && cnt_q != '0 && !wr_t) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !wr_t) |=> (cnt_q == '0));

  p_pend_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(tick && run_q && ien_q && !wr_t && cnt_q == 1));

  p_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_t && wr_data[ACK_BIT]) |=> !pend_q);

  p_wr_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_t |=> (cnt_q == $past(wr_data[CNT_W-1:0])));

  p_stat_rsv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(STAT_OFS)) |-> (rd_data[DATA_W-1:6] == '0));

  p_irq_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((|src_req) || pend_q));
endmodule

bind tick_timer_irq tt_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .ACK_BIT(ACK_BIT),
  .EXT_SRC(EXT_SRC), .TIMER_OFS(TIMER_OFS), .STAT_OFS(STAT_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .tick(tick), .src_req(src_req), .irq(irq),
  .cnt_q(cnt_q), .run_q(ctl_q.run), .ien_q(ctl_q.ien), .pend_q(pend_q)
);

// File: tb/tick_timer_irq_test.sv
module tick_timer_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tick = 1'b0;
  logic [4:0]  src_req = '0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // behavioural reference state
  int m_count = 0;
  bit m_run = 0, m_ien = 0, m_pend = 0;

  always #10 clk = ~clk;

  tick_timer_irq uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .src_req(src_req), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    logic [31:0] e = '0;
    if (a == 8'h60) e = 32'(m_count) | (32'(m_run) << 24) | (32'(m_ien) << 25);
    else if (a == 8'h64) e = 32'(src_req) | (32'(m_pend) << 5);
    return e;
  endfunction

  // reference model advance (R1 R2 R3 R4 R5 R6)
  always @(posedge clk) begin
    if (!rst_n) begin
      m_count = 0; m_run = 0; m_ien = 0; m_pend = 0;
    end else if (wr_en && addr == 8'h60) begin
      m_count = int'(wr_data[19:0]);
      m_run = wr_data[24];
      m_ien = wr_data[25];
      if (wr_data[26]) m_pend = 0;
    end else if (tick && m_run && m_count != 0) begin
      if (m_count == 1 && m_ien) m_pend = 1;
      m_count = m_count - 1;
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(rd_data == model_rd(addr), "R1/R7/R10 rd_data vs model", rd_data, model_rd(addr));
      check(irq == ((src_req != 0) || m_pend), "R8 irq vs model", {31'b0, irq},
            {31'b0, (src_req != 0) || m_pend});
    end
    if (cycles > 5000) begin
      check(1'b0, "watchdog", 32'(cycles), 32'd5000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic drive(input bit we, input logic [7:0] a, input logic [31:0] d, input bit tk);
    @(negedge clk); #1;
    wr_en = we; addr = a; wr_data = d; tick = tk;
  endtask

  task automatic ticks(input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      drive(0, 8'h60, 0, 1);
      if (gap) drive(0, 8'h60, 0, 0);
    end
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] v);
    drive(0, a, 0, 0);
    @(negedge clk);
    v = rd_data;
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    peek(8'h60, v); check(v == 0, "R9 control word after reset", v, 0);
    peek(8'h64, v); check(v == 0 && irq == 0, "R9 status after reset", v, 0);

    drive(1, 8'h60, 32'h0300_0005, 0);
    ticks(4, 0);
    peek(8'h60, v); check(v == 32'h0300_0001, "R2 back-to-back ticks", v, 32'h0300_0001);
    check(irq == 0, "R4 no irq before zero", {31'b0, irq}, 0);
    ticks(1, 0);
    peek(8'h64, v); check(v == 32'h20, "R4 pending on 1->0", v, 32'h20);
    ticks(3, 0);
    peek(8'h60, v); check(v == 32'h0300_0000, "R3 holds at zero", v, 32'h0300_0000);

    drive(1, 8'h60, 32'h0700_0003, 0);
    peek(8'h64, v); check(v == 0, "R5 ack clears pending", v, 0);
    peek(8'h60, v); check(v == 32'h0300_0003, "R5 ack write loads count", v, 32'h0300_0003);

    drive(1, 8'h60, 32'h0200_0003, 0);
    ticks(3, 0);
    peek(8'h60, v); check(v == 32'h0200_0003, "R2 run clear holds", v, 32'h0200_0003);

    drive(1, 8'h60, 32'h0100_0002, 0);
    ticks(4, 1);
    peek(8'h64, v); check(v == 0, "R4 no pending when enable off", v, 0);

    drive(1, 8'h60, 32'h0300_0000, 0);
    ticks(2, 0);
    peek(8'h64, v); check(v == 0, "R4 direct zero load no pending", v, 0);

    drive(1, 8'h60, 32'h0300_0001, 0);
    drive(1, 8'h60, 32'h0300_0009, 1);
    peek(8'h60, v); check(v == 32'h0300_0009, "R6 write beats tick", v, 32'h0300_0009);
    check(irq == 0, "R6 no irq from overridden tick", {31'b0, irq}, 0);

    ticks(8, 1);
    peek(8'h60, v); check(v == 32'h0300_0001, "R2 gapped ticks", v, 32'h0300_0001);
    ticks(1, 1);

    src_req = 5'b10101;
    peek(8'h64, v); check(v == 32'h35, "R7 status bit positions", v, 32'h35);
    drive(1, 8'h64, 32'hFFFF_FFFF, 0);
    peek(8'h64, v); check(v == 32'h35, "R7 status write ignored", v, 32'h35);
    peek(8'h60, v); check(v == 32'h0300_0000, "R7 status write leaves timer", v, 32'h0300_0000);

    drive(1, 8'h60, 32'h0400_0000, 0);
    src_req = 5'b00000;
    peek(8'h64, v); check(irq == 0, "R8 irq low with empty status", {31'b0, irq}, 0);
    src_req = 5'b01000;
    peek(8'h64, v); check(irq == 1 && v == 32'h08, "R8 irq from game-port bit", v, 32'h08);
    src_req = 5'b00000;

    drive(1, 8'h60, 32'hFFFF_FFFF, 0);
    peek(8'h60, v); check(v == 32'h030F_FFFF, "R1 full word readback", v, 32'h030F_FFFF);
    peek(8'h40, v); check(v == 0, "R10 other address reads zero", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule